// File: doc/BRIEF.md
# Counter Enable Clear Register

This block holds the enable state of the counters in a performance-monitoring unit. There is one cycle counter and up to 31 event counters. A debug agent reaches the register through a small memory-mapped port that carries an address, write data, a write flag and a select. The block answers each access it claims one cycle later, with a response valid, an error flag and read data. Writing a one to a bit turns the matching counter off. Reading shows which counters are running at that moment. A companion set register can turn counters on through a separate pulse-and-mask input. The enable vector drives the counters directly.

The block decides how each access is treated from five status inputs: core power, double lock, OS lock, external-access permission and software lock. With the core powered, both locks clear and external access allowed, the register is read-write when the software lock is clear and read-only when it is set. Every other combination turns an access into an error response and leaves the register untouched.

The number of implemented event counters is a parameter. Bits above the implemented range always read as zero, and neither writes nor sets reach them.

Top module: `cnt_enable_clear`

## Requirements
- R1: Bit 31 of the register and of `cntEnable` belongs to the cycle counter. Bit n (n from 0 to 30) belongs to event counter n. `cntEnable` always equals the register contents.
- R2: In read-write mode, a write to offset 0xC20 clears every bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R3: A read that is accepted in read-write or read-only mode produces `respValid`=1 and `respErr`=0 on the next cycle. On that cycle `respData` holds the enable vector as it was in the access cycle, with 1 meaning enabled. A write response carries `respData`=0.
- R4: When `EVT_COUNT` is below 31, bits 30 down to `EVT_COUNT` always read as 0. Clearing or setting them has no effect.
- R5: The block claims only accesses whose `busAddr` equals the offset 0xC20. Any other address gives no response and leaves the register unchanged.
- R6: Read-only mode applies when `powerOn`=1, `dblLock`=0, `osLock`=0, `extAllowed`=1 and `swLock`=1. In that mode a write responds with `respErr`=0 and changes nothing, and a read returns the current state.
- R7: When `powerOn`=0, `dblLock`=1, `osLock`=1 or `extAllowed`=0, an access responds with `respErr`=1 and `respData`=0, and the register does not change.
- R8: `rstCoreN` low clears all enable bits to 0. `rstDbgN` resets only the response path and leaves the enable bits as they were.
- R9: A cycle with `setPulse`=1 sets every implemented bit that is 1 in `setMask`. If a clear by write and a set hit the same bit in the same cycle, the bit ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstCoreN | input | 1 | Core reset, active low, clears the enable bits |
| rstDbgN | input | 1 | Debug reset, active low, resets the response path only |
| busSel | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset of the access |
| busWdata | input | 32 | Write data, ones clear enable bits |
| respValid | output | 1 | Response for the access of the previous cycle |
| respErr | output | 1 | Error response |
| respData | output | 32 | Read data |
| powerOn | input | 1 | Core is powered |
| dblLock | input | 1 | Double lock active |
| osLock | input | 1 | OS lock active |
| extAllowed | input | 1 | External access to the monitoring unit permitted |
| swLock | input | 1 | Software lock set (makes the register read-only) |
| setPulse | input | 1 | Apply `setMask` this cycle |
| setMask | input | 32 | Bits to enable |
| cntEnable | output | 32 | Enable vector to the counters |

## Verification
The register is driven with full, empty and sparse clear masks. The sparse masks include the cycle-counter bit and event bit 0, which separates per-bit clearing from whole-word clearing and confirms that writing zeros changes nothing. The clear masks run in three configurations (6, 31 and 0 event counters), so the unimplemented range is exercised where it is wide, where it is empty, and where it covers every event bit. Each status input is dropped in turn to tell read-only from error handling. A set and a clear land on the same bits in one cycle to show which one wins. Accesses to a neighbouring offset and a pulse on the debug reset show that neither reaches the enable bits.

// File: rtl/cec_pkg.sv
package cec_pkg;

  typedef enum logic [1:0] {
    ACC_ERR = 2'd0,
    ACC_RO  = 2'd1,
    ACC_RW  = 2'd2
  } accModeT;

  // strobes from the control to the datapath
  typedef struct packed {
    logic clrEn;   // apply write data as a clear mask
    logic rdEn;    // capture the enable vector as read data
    logic respEn;  // load the read data register
  } dpStrobeT;

  localparam int unsigned REG_W   = 32;
  localparam int unsigned MAX_EVT = 31;

endpackage

// File: rtl/cec_ctrl.sv
module cec_ctrl
  import cec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hC20
) (
  input  logic              clk,
  input  logic              rstDbgN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              powerOn,
  input  logic              dblLock,
  input  logic              osLock,
  input  logic              extAllowed,
  input  logic              swLock,
  output dpStrobeT          strb,
  output logic              respValid,
  output logic              respErr
);

  accModeT accMode;
  logic    addrHit;
  logic    gateOpen;

  assign gateOpen = powerOn && !dblLock && !osLock && extAllowed;
  assign addrHit  = busSel && (busAddr == REG_OFFSET);

  always_comb begin
    if (!gateOpen)   accMode = ACC_ERR;
    else if (swLock) accMode = ACC_RO;
    else             accMode = ACC_RW;
  end

  always_comb begin
    strb        = '0;
    strb.respEn = addrHit;
    strb.clrEn  = addrHit && busWrite && (accMode == ACC_RW);
    strb.rdEn   = addrHit && !busWrite && (accMode != ACC_ERR);
  end

  always_ff @(posedge clk or negedge rstDbgN) begin
    if (!rstDbgN) begin
      respValid <= 1'b0;
      respErr   <= 1'b0;
    end else begin
      respValid <= addrHit;
      respErr   <= addrHit && (accMode == ACC_ERR);
    end
  end

  // R7
  gate_err_chk: assert property (@(posedge clk) disable iff (!rstDbgN)
    (busSel && busAddr == REG_OFFSET && (!powerOn || dblLock || osLock || !extAllowed))
      |=> (respValid && respErr));

  // R6
  ro_no_err_chk: assert property (@(posedge clk) disable iff (!rstDbgN)
    (busSel && busAddr == REG_OFFSET && powerOn && !dblLock && !osLock && extAllowed && swLock)
      |=> (respValid && !respErr));

  // R5
  miss_no_resp_chk: assert property (@(posedge clk) disable iff (!rstDbgN)
    (!busSel || busAddr != REG_OFFSET) |=> !respValid);

  // R6
  ro_no_clear_chk: assert property (@(posedge clk) disable iff (!rstDbgN)
    swLock |-> !strb.clrEn);

endmodule

// File: rtl/cec_datapath.sv
module cec_datapath
  import cec_pkg::*;
#(
  parameter int unsigned EVT_COUNT = 31
) (
  input  logic             clk,
  input  logic             rstCoreN,
  input  logic             rstDbgN,
  input  dpStrobeT         strb,
  input  logic [REG_W-1:0] wdata,
  input  logic             setPulse,
  input  logic [REG_W-1:0] setMask,
  output logic [REG_W-1:0] enReg,
  output logic [REG_W-1:0] respData
);

  localparam int unsigned EVT_N = (EVT_COUNT > MAX_EVT) ? MAX_EVT : EVT_COUNT;
  localparam logic [MAX_EVT-1:0] EVT_MASK = MAX_EVT'((64'(1) << EVT_N) - 64'(1));
  localparam logic [REG_W-1:0] IMPL_MASK = {1'b1, EVT_MASK};

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic bitQ;
      always_ff @(posedge clk or negedge rstCoreN) begin
        if (!rstCoreN)                     bitQ <= 1'b0;
        else if (strb.clrEn && wdata[i])   bitQ <= 1'b0;
        else if (setPulse && setMask[i])   bitQ <= 1'b1;
      end
      assign enReg[i] = bitQ;
    end else begin : g_raz
      assign enReg[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstDbgN) begin
    if (!rstDbgN)          respData <= '0;
    else if (strb.respEn)  respData <= strb.rdEn ? enReg : '0;
  end

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rstCoreN)
    strb.clrEn |=> ((enReg & $past(wdata)) == '0));

  // R9
  set_chk: assert property (@(posedge clk) disable iff (!rstCoreN)
    (setPulse && !strb.clrEn) |=> ((enReg & $past(setMask & IMPL_MASK)) == $past(setMask & IMPL_MASK)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstCoreN)
    (!strb.clrEn && !setPulse) |=> $stable(enReg));

  // R3
  read_chk: assert property (@(posedge clk) disable iff (!rstCoreN || !rstDbgN)
    strb.rdEn |=> (respData == $past(enReg)));

endmodule

// File: rtl/cnt_enable_clear.sv
module cnt_enable_clear
  import cec_pkg::*;
#(
  parameter int unsigned EVT_COUNT  = 31,
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hC20
) (
  input  logic              clk,
  input  logic              rstCoreN,
  input  logic              rstDbgN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              respValid,
  output logic              respErr,
  output logic [31:0]       respData,
  input  logic              powerOn,
  input  logic              dblLock,
  input  logic              osLock,
  input  logic              extAllowed,
  input  logic              swLock,
  input  logic              setPulse,
  input  logic [31:0]       setMask,
  output logic [31:0]       cntEnable
);

  dpStrobeT strb;

  cec_ctrl #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
  ) u_ctrl (
    .clk        (clk),
    .rstDbgN    (rstDbgN),
    .busSel     (busSel),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .powerOn    (powerOn),
    .dblLock    (dblLock),
    .osLock     (osLock),
    .extAllowed (extAllowed),
    .swLock     (swLock),
    .strb       (strb),
    .respValid  (respValid),
    .respErr    (respErr)
  );

  cec_datapath #(
    .EVT_COUNT (EVT_COUNT)
  ) u_dp (
    .clk      (clk),
    .rstCoreN (rstCoreN),
    .rstDbgN  (rstDbgN),
    .strb     (strb),
    .wdata    (busWdata),
    .setPulse (setPulse),
    .setMask  (setMask),
    .enReg    (cntEnable),
    .respData (respData)
  );

endmodule

// File: tb/cnt_enable_clear_bench.sv
module cnt_enable_clear_bench;

  localparam int N_A = 6;
  localparam int N_B = 31;
  localparam int N_C = 0;
  localparam logic [11:0] OFS = 12'hC20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstCoreN, rstDbgN, busSel, busWrite;
  logic [11:0] busAddr;
  logic [31:0] busWdata, setMask;
  logic powerOn, dblLock, osLock, extAllowed, swLock, setPulse;

  logic        rv0, rv1, rv2, re0, re1, re2;
  logic [31:0] rd0, rd1, rd2, en0, en1, en2;

  cnt_enable_clear #(.EVT_COUNT(N_A)) u_cnt_enable_clear (
    .clk(clk), .rstCoreN(rstCoreN), .rstDbgN(rstDbgN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .respValid(rv0), .respErr(re0), .respData(rd0),
    .powerOn(powerOn), .dblLock(dblLock), .osLock(osLock), .extAllowed(extAllowed),
    .swLock(swLock), .setPulse(setPulse), .setMask(setMask), .cntEnable(en0));

  cnt_enable_clear #(.EVT_COUNT(N_B)) u_cnt_enable_clear_full (
    .clk(clk), .rstCoreN(rstCoreN), .rstDbgN(rstDbgN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .respValid(rv1), .respErr(re1), .respData(rd1),
    .powerOn(powerOn), .dblLock(dblLock), .osLock(osLock), .extAllowed(extAllowed),
    .swLock(swLock), .setPulse(setPulse), .setMask(setMask), .cntEnable(en1));

  cnt_enable_clear #(.EVT_COUNT(N_C)) u_cnt_enable_clear_none (
    .clk(clk), .rstCoreN(rstCoreN), .rstDbgN(rstDbgN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .respValid(rv2), .respErr(re2), .respData(rd2),
    .powerOn(powerOn), .dblLock(dblLock), .osLock(osLock), .extAllowed(extAllowed),
    .swLock(swLock), .setPulse(setPulse), .setMask(setMask), .cntEnable(en2));

  typedef struct {
    bit          err;
    logic [31:0] d0, d1, d2;
    string       tag;
  } expT;

  expT sbq[$];
  int numChecks = 0;
  int numFails  = 0;
  logic [31:0] mdl0, mdl1, mdl2;
  logic [31:0] msk0, msk1, msk2;

  function automatic logic [31:0] maskFor(int n);
    return {1'b1, 31'((64'(1) << n) - 64'(1))};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    numChecks++;
    if (!ok) begin
      numFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkEn(string tag);
    chk(en0 === mdl0, {tag, " en N=6"},  en0, mdl0);
    chk(en1 === mdl1, {tag, " en N=31"}, en1, mdl1);
    chk(en2 === mdl2, {tag, " en N=0"},  en2, mdl2);
  endtask

  // driver: one access cycle, pushes the expected response, updates the model
  task automatic cyc(bit s, bit w, logic [11:0] a, logic [31:0] d,
                     bit sp, logic [31:0] sm, string tag);
    bit hit, open;
    logic [31:0] clr, st;
    expT e;
    @(negedge clk);
    busSel = s; busWrite = w; busAddr = a; busWdata = d; setPulse = sp; setMask = sm;
    hit  = s && (a == OFS);
    open = powerOn && !dblLock && !osLock && extAllowed;
    if (hit) begin
      e.err = !open;
      e.d0  = (open && !w) ? mdl0 : 32'h0;
      e.d1  = (open && !w) ? mdl1 : 32'h0;
      e.d2  = (open && !w) ? mdl2 : 32'h0;
      e.tag = tag;
      sbq.push_back(e);
    end
    clr  = (hit && open && !swLock && w) ? d : 32'h0;
    st   = sp ? sm : 32'h0;
    mdl0 = ((mdl0 | st) & ~clr) & msk0;
    mdl1 = ((mdl1 | st) & ~clr) & msk1;
    mdl2 = ((mdl2 | st) & ~clr) & msk2;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; setPulse = 1'b0; setMask = '0; busWdata = '0;
    if (!hit) chk(rv0 === 1'b0, {tag, " no response"}, 32'(rv0), 32'h0);
    chkEn(tag);
  endtask

  // monitor: pops the scoreboard when a response shows up
  always @(negedge clk) begin
    if (rstDbgN && rv0) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R5 unexpected response", 32'h1, 32'h0);
      end else begin
        expT e;
        e = sbq.pop_front();
        chk(re0 === e.err && re1 === e.err && re2 === e.err, {e.tag, " respErr"},
            {29'h0, re2, re1, re0}, {29'h0, {3{e.err}}});
        chk(rv1 === 1'b1 && rv2 === 1'b1, {e.tag, " respValid"}, {30'h0, rv2, rv1}, 32'h3);
        chk(rd0 === e.d0, {e.tag, " data N=6"},  rd0, e.d0);
        chk(rd1 === e.d1, {e.tag, " data N=31"}, rd1, e.d1);
        chk(rd2 === e.d2, {e.tag, " data N=0"},  rd2, e.d2);
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", numChecks, numFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    numChecks++;
    numFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    msk0 = maskFor(N_A); msk1 = maskFor(N_B); msk2 = maskFor(N_C);
    mdl0 = '0; mdl1 = '0; mdl2 = '0;
    rstCoreN = 1'b0; rstDbgN = 1'b0;
    busSel = 1'b0; busWrite = 1'b0; busAddr = '0; busWdata = '0;
    setPulse = 1'b0; setMask = '0;
    powerOn = 1'b1; dblLock = 1'b0; osLock = 1'b0; extAllowed = 1'b1; swLock = 1'b0;
    repeat (3) @(negedge clk);
    chkEn("R8 reset");
    chk(rv0 === 1'b0, "R8 reset respValid", 32'(rv0), 32'h0);
    rstCoreN = 1'b1; rstDbgN = 1'b1;

    cyc(0, 0, OFS, '0, 1, 32'hFFFF_FFFF, "R9 set all");
    cyc(1, 0, OFS, '0, 0, '0, "R3 read all set");
    cyc(1, 1, OFS, 32'h8000_0001, 0, '0, "R1 R2 clear cycle bit and bit0");
    cyc(1, 1, OFS, 32'h0, 0, '0, "R2 write zero");
    cyc(1, 0, OFS, '0, 0, '0, "R3 read after clear");
    cyc(1, 1, OFS, 32'h0000_0FF0, 0, '0, "R4 clear across boundary");
    cyc(0, 0, OFS, '0, 1, 32'h7FFF_FFC0, "R4 set unimplemented");
    cyc(1, 0, OFS, '0, 0, '0, "R4 read raz");
    cyc(1, 1, OFS, 32'h0000_0003, 1, 32'hFFFF_FFFF, "R9 set and clear same cycle");
    cyc(1, 0, OFS, '0, 0, '0, "R9 read after collision");

    swLock = 1'b1;
    cyc(1, 1, OFS, 32'hFFFF_FFFF, 0, '0, "R6 write read-only");
    cyc(1, 0, OFS, '0, 0, '0, "R6 read read-only");
    swLock = 1'b0;

    powerOn = 1'b0;
    cyc(1, 0, OFS, '0, 0, '0, "R7 read unpowered");
    cyc(1, 1, OFS, 32'hFFFF_FFFF, 0, '0, "R7 write unpowered");
    powerOn = 1'b1; dblLock = 1'b1;
    cyc(1, 1, OFS, 32'hFFFF_FFFF, 0, '0, "R7 write double lock");
    dblLock = 1'b0; osLock = 1'b1;
    cyc(1, 0, OFS, '0, 0, '0, "R7 read os lock");
    osLock = 1'b0; extAllowed = 1'b0; swLock = 1'b1;
    cyc(1, 1, OFS, 32'hFFFF_FFFF, 0, '0, "R7 write no external access");
    extAllowed = 1'b1; swLock = 1'b0;

    cyc(1, 1, 12'hC24, 32'hFFFF_FFFF, 0, '0, "R5 write other offset");
    cyc(1, 0, 12'hC00, '0, 0, '0, "R5 read other offset");
    cyc(1, 0, OFS, '0, 0, '0, "R3 read after misses");

    @(negedge clk); rstDbgN = 1'b0;
    @(negedge clk); rstDbgN = 1'b1;
    @(negedge clk);
    chkEn("R8 debug reset keeps enables");

    @(negedge clk); rstCoreN = 1'b0;
    mdl0 = '0; mdl1 = '0; mdl2 = '0;
    @(negedge clk); rstCoreN = 1'b1;
    chkEn("R8 core reset clears");
    cyc(1, 0, OFS, '0, 0, '0, "R8 read after core reset");

    repeat (2) @(negedge clk);
    chk(sbq.size() == 0, "R3 scoreboard drained", 32'(sbq.size()), 32'h0);
    finishRun();
  end

endmodule